// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how long a slow clock takes to complete a programmed number of its own cycles, in units of a fast reference clock. Four slow sources arrive as free-running level signals. Each passes through a two-flop synchroniser and a rising-edge detector in the reference domain, and a 2-bit select chooses which one is measured. Software programs the source, the number of slow cycles and a timeout threshold, then raises the start bit. The block counts reference cycles until the chosen number of slow rising edges has been seen, then raises a ready flag and holds the count in a result register.

A run that takes longer than the threshold allows is stopped. The timeout flag is raised and the internal counters are cleared, so the next run starts clean. A cycling mode restarts the measurement on its own after every completion, and the result is refreshed each period. A small word-addressed register port gives access to control, threshold, status and result.

Top module: `slow_cal_counter`

## Requirements
- R1: The select field (control bits [3:2]) picks the measured input: 0 measures slow_in[0] (the muxed slow clock), 1 measures slow_in[1] (fast RC divided by 256), 2 measures slow_in[2] (32 kHz crystal), 3 measures slow_in[3] (internal RC).
- R2: Register map, 32-bit words: address 0 is control (bit 0 start, bit 1 cycling, bits [3:2] select, bits [31:16] slow-cycle count, other bits read 0). Address 1 is the threshold in bits [REF_W-1:0]. Address 2 is status (bit 0 ready, bit 1 timeout, bit 2 busy). Address 3 is the result in bits [REF_W-1:0]. Writes to addresses 2 and 3 have no effect.
- R3: A run begins only on a 0-to-1 change of the start bit. Holding start at 1 does not begin another run.
- R4: In a run with a nonzero count N, the result is the number of reference edges from the edge after start was seen up to and including the edge on which the Nth synchronised slow rising edge is counted. Ready then sets and busy clears.
- R5: While busy, if the elapsed reference count is greater than the threshold, timeout sets, ready and busy clear, and the result keeps its previous value. A later run is unaffected.
- R6: A slow rising edge that is first sampled at reference edge k is counted at reference edge k+2.
- R7: With the cycling bit set, each completion updates the result and sets ready, and busy stays 1 as counting restarts from zero. After the cycling bit is cleared, the next completion ends the run.
- R8: A start edge while a run is busy is ignored. The run in progress continues and is not restarted.
- R9: A 1-to-0 change of the start bit clears ready and timeout and leaves the result unchanged.
- R10: A start edge with a count of zero sets ready on the next reference edge with a result of 0, and busy stays 0.
- R11: The reference counter is REF_W bits wide (default 25) and saturates at all ones instead of wrapping.
- R12: After reset, all registers, flags and the result read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| slow_in | input | 4 | Slow clock sources, asynchronous to clk |

## Verification
The bench targets the synchroniser latency with a hand-driven edge. A design that gets it wrong shows ready one cycle early or late. It toggles start while a long run is busy: a design that restarts finishes far past the expected time. It forces a timeout with a small threshold and checks that the previous result survives and that a following run measures correctly, which catches counters left dirty after an abort. It checks a zero count, where a wrong design hangs busy, and a run longer than the counter range, where a wrapping counter returns a small value instead of all ones.

// File: rtl/cal_pkg.sv
`timescale 1ns/100ps
package cal_pkg;
    localparam int BUS_W = 32;
    localparam int CNT_W = 16;
    localparam int NSRC  = 4;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        SRC_MUX   = 2'd0,
        SRC_RC256 = 2'd1,
        SRC_XTAL  = 2'd2,
        SRC_IRC   = 2'd3
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_THR  = 2'd1,
        A_STAT = 2'd2,
        A_RES  = 2'd3
    } addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] cycles;
        logic [11:0]      pad;
        src_e             sel;
        logic             cyc;
        logic             start;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic tmo;
        logic ready;
    } stat_t;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] vmax);
        return (v >= vmax) ? vmax : v + 32'd1;
    endfunction
endpackage

// File: rtl/cal_edge_sync.sv
`timescale 1ns/100ps
module cal_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pulse = s2 & ~s3;
endmodule

// File: rtl/cal_regs.sv
`timescale 1ns/100ps
module cal_regs
    import cal_pkg::*;
#(
    parameter int REF_W = 25
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    input  stat_t               stat,
    input  logic [REF_W-1:0]    result,
    output ctrl_t               ctrl,
    output logic [REF_W-1:0]    thresh,
    output logic [BUS_W-1:0]    rdata
);
    ctrl_t ctrl_q;
    logic [REF_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            thr_q  <= '0;
        end else if (wr) begin
            case (addr_e'(addr))
                A_CTRL: begin
                    ctrl_q     <= ctrl_t'(wdata);
                    ctrl_q.pad <= '0;
                end
                A_THR:   thr_q <= wdata[REF_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr_e'(addr))
            A_CTRL:  rdata = BUS_W'(ctrl_q);
            A_THR:   rdata = BUS_W'(thr_q);
            A_STAT:  rdata = BUS_W'(stat);
            default: rdata = BUS_W'(result);
        endcase
    end

    assign ctrl   = ctrl_q;
    assign thresh = thr_q;
endmodule

// File: rtl/cal_engine.sv
`timescale 1ns/100ps
module cal_engine
    import cal_pkg::*;
#(
    parameter int REF_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [REF_W-1:0]  thresh,
    input  logic [NSRC-1:0]   pulses,
    output stat_t             stat,
    output logic [REF_W-1:0]  result
);
    localparam logic [REF_W-1:0] REF_MAX = '1;

    logic             start_d;
    logic             busy, ready, tmo;
    logic [REF_W-1:0] refcnt, res_q, ref_next;
    logic [CNT_W-1:0] slowcnt;
    logic             go, fall, sel_pulse, last_edge, over;

    assign go        = ctrl.start & ~start_d;
    assign fall      = ~ctrl.start & start_d;
    assign sel_pulse = pulses[ctrl.sel];
    assign ref_next  = REF_W'(sat_inc(32'(refcnt), 32'(REF_MAX)));
    assign last_edge = sel_pulse && ((slowcnt + CNT_W'(1)) == ctrl.cycles);
    assign over      = refcnt > thresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_d <= 1'b0;
            busy    <= 1'b0;
            ready   <= 1'b0;
            tmo     <= 1'b0;
            refcnt  <= '0;
            slowcnt <= '0;
            res_q   <= '0;
        end else begin
            start_d <= ctrl.start;
            if (fall) begin
                ready <= 1'b0;
                tmo   <= 1'b0;
            end
            if (busy) begin
                if (last_edge) begin
                    res_q   <= ref_next;
                    ready   <= 1'b1;
                    tmo     <= 1'b0;
                    refcnt  <= '0;
                    slowcnt <= '0;
                    busy    <= ctrl.cyc;
                end else if (over) begin
                    tmo     <= 1'b1;
                    ready   <= 1'b0;
                    busy    <= 1'b0;
                    refcnt  <= '0;
                    slowcnt <= '0;
                end else begin
                    refcnt <= ref_next;
                    if (sel_pulse) slowcnt <= slowcnt + CNT_W'(1);
                end
            end else if (go) begin
                tmo <= 1'b0;
                if (ctrl.cycles == '0) begin
                    ready <= 1'b1;
                    res_q <= '0;
                end else begin
                    ready   <= 1'b0;
                    busy    <= 1'b1;
                    refcnt  <= '0;
                    slowcnt <= '0;
                end
            end
        end
    end

    assign stat   = '{busy: busy, tmo: tmo, ready: ready};
    assign result = res_q;

    // R5
    ready_tmo_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ready && tmo));

    // R5
    tmo_stops_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo) |-> !busy);

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !busy && ctrl.cycles == '0) |=> (ready && res_q == '0 && !busy));

    // R3
    go_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));

    // R11
    ref_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && refcnt == REF_MAX && !last_edge && !over) |=> (refcnt == REF_MAX));
endmodule

// File: rtl/slow_cal_counter.sv
`timescale 1ns/100ps
module slow_cal_counter
    import cal_pkg::*;
#(
    parameter int REF_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        slow_in
);
    logic [NSRC-1:0]  pulses;
    ctrl_t            ctrl;
    logic [REF_W-1:0] thresh;
    logic [REF_W-1:0] result;
    stat_t            stat;

    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        cal_edge_sync u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (slow_in[i]),
            .pulse    (pulses[i])
        );
    end

    cal_regs #(.REF_W(REF_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .stat   (stat),
        .result (result),
        .ctrl   (ctrl),
        .thresh (thresh),
        .rdata  (reg_rdata)
    );

    cal_engine #(.REF_W(REF_W)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .thresh (thresh),
        .pulses (pulses),
        .stat   (stat),
        .result (result)
    );
endmodule

// File: tb/sim_slow_cal_counter.sv
`timescale 1ns/100ps
module sim_slow_cal_counter;
    localparam int RW   = 10;
    localparam int RMAX = (1 << RW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tb_wr = 1'b0;
    logic [1:0]  tb_addr = 2'd0, mon_addr = 2'd0, reg_addr;
    logic        mon_on = 1'b0;
    logic [31:0] tb_wdata = 32'd0, reg_rdata;
    logic        auto0 = 1'b0, man0 = 1'b0, src0_auto = 1'b0;
    logic        v1 = 1'b0, v2 = 1'b0, v3 = 1'b0;
    logic [3:0]  slow_in;

    integer checks = 0, errors = 0, cyc_now = 0;

    assign reg_addr = mon_on ? mon_addr : tb_addr;
    assign slow_in  = {v3, v2, v1, src0_auto ? auto0 : man0};

    always #2 clk = ~clk;

    slow_cal_counter #(.REF_W(RW)) u0 (
        .clk(clk), .rst(rst), .reg_wr(tb_wr), .reg_addr(reg_addr),
        .reg_wdata(tb_wdata), .reg_rdata(reg_rdata), .slow_in(slow_in)
    );

    initial forever begin repeat (6)  @(negedge clk); auto0 = ~auto0; end
    initial forever begin repeat (5)  @(negedge clk); v1 = ~v1; end
    initial forever begin repeat (9)  @(negedge clk); v2 = ~v2; end
    initial forever begin repeat (20) @(negedge clk); v3 = ~v3; end

    // behavioural reference model
    integer m_cycles = 0, m_sel = 0, m_thr = 0, m_ref = 0, m_slow = 0, m_res = 0, m_done = 0;
    bit m_start = 0, m_cyc = 0, m_prev = 0, m_busy = 0, m_rdy = 0, m_tmo = 0;
    logic [3:0] h1 = 0, h2 = 0, h3 = 0;

    always @(posedge clk) begin
        cyc_now = cyc_now + 1;
        if (rst) begin
            m_cycles = 0; m_sel = 0; m_thr = 0; m_ref = 0; m_slow = 0; m_res = 0;
            m_start = 0; m_cyc = 0; m_prev = 0; m_busy = 0; m_rdy = 0; m_tmo = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            logic [3:0] pl;
            bit p;
            integer nr;
            pl = h2 & ~h3;
            p  = pl[m_sel];
            if (!m_start && m_prev) begin m_rdy = 0; m_tmo = 0; end
            if (m_busy) begin
                nr = (m_ref >= RMAX) ? RMAX : m_ref + 1;
                if (p && (m_slow + 1 == m_cycles)) begin
                    m_res = nr; m_rdy = 1; m_tmo = 0; m_ref = 0; m_slow = 0;
                    m_busy = m_cyc; m_done = m_done + 1;
                end else if (m_ref > m_thr) begin
                    m_tmo = 1; m_rdy = 0; m_busy = 0; m_ref = 0; m_slow = 0;
                end else begin
                    m_ref = nr;
                    if (p) m_slow = m_slow + 1;
                end
            end else if (m_start && !m_prev) begin
                m_tmo = 0;
                if (m_cycles == 0) begin m_rdy = 1; m_res = 0; end
                else begin m_rdy = 0; m_busy = 1; m_ref = 0; m_slow = 0; end
            end
            h3 = h2; h2 = h1; h1 = slow_in;
            m_prev = m_start;
            if (tb_wr) begin
                if (tb_addr == 2'd0) begin
                    m_start = tb_wdata[0]; m_cyc = tb_wdata[1];
                    m_sel = int'(tb_wdata[3:2]); m_cycles = int'(tb_wdata[31:16]);
                end else if (tb_addr == 2'd1) begin
                    m_thr = int'(tb_wdata[RW-1:0]);
                end
            end
        end
    end

    task automatic chk(input string tag, input integer act, input integer exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_in(input string tag, input integer act, input integer lo, input integer hi);
        checks = checks + 1;
        if (act < lo || act > hi) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #0.5 mon_addr = 2'd2; mon_on = 1'b1;
        #0.2 if (!rst) chk("R2 status vs model", int'(reg_rdata), int'({m_busy, m_tmo, m_rdy}));
        mon_addr = 2'd3;
        #0.2 if (!rst) chk("R4 result vs model", int'(reg_rdata), m_res);
        mon_on = 1'b0;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); tb_wr = 1'b1; tb_addr = a; tb_wdata = d;
        @(negedge clk); tb_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [1:0] a, output integer d);
        tb_addr = a; #0.2 d = int'(reg_rdata);
    endtask

    task automatic rd(input logic [1:0] a, output integer d);
        @(posedge clk); #1.5 rd_now(a, d);
    endtask

    function automatic logic [31:0] mk(input integer n, input integer sel, input bit c, input bit s);
        return {n[15:0], 12'd0, sel[1:0], c, s};
    endfunction

    task automatic launch(input integer n, input integer sel, input bit c);
        wr(2'd0, mk(n, sel, c, 1'b0));
        wr(2'd0, mk(n, sel, c, 1'b1));
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && (m_busy || !(m_rdy || m_tmo)); i++) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic wait_done(input integer n);
        integer tgt;
        tgt = m_done + n;
        for (int i = 0; i < 8000 && m_done < tgt; i++) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        integer d, t0, saved;
        int hp[4];
        hp[0] = 6; hp[1] = 5; hp[2] = 9; hp[3] = 20;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state
        rd(2'd2, d); chk("R12 status after reset", d, 0);
        rd_now(2'd3, d); chk("R12 result after reset", d, 0);
        rd_now(2'd0, d); chk("R12 control after reset", d, 0);
        rd_now(2'd1, d); chk("R12 threshold after reset", d, 0);

        // R2 map and ignored writes
        wr(2'd1, 32'd1000);
        rd(2'd1, d); chk("R2 threshold readback", d, 1000);
        wr(2'd0, mk(4, 1, 1'b0, 1'b0) | 32'h0000_FF00);
        rd(2'd0, d); chk("R2 control readback, reserved bits 0", d, int'(mk(4, 1, 1'b0, 1'b0)));
        wr(2'd3, 32'd55); wr(2'd2, 32'd7);
        rd(2'd3, d); chk("R2 write to result ignored", d, 0);
        rd_now(2'd2, d); chk("R2 write to status ignored", d, 0);

        // R4 one-shot on source 1 (rising edge every 10 cycles)
        wr(2'd0, mk(4, 1, 1'b0, 1'b1));
        wait_idle();
        rd(2'd2, d); chk("R4 ready set, busy clear", d, 1);
        rd_now(2'd3, d); chk_in("R4 result range", d, 31, 43);
        saved = d;

        // R3 holding start does not rerun
        repeat (60) @(posedge clk);
        rd(2'd2, d); chk("R3 held start no rerun", d, 1);

        // R9 falling start clears flags
        wr(2'd0, mk(4, 1, 1'b0, 1'b0));
        rd(2'd2, d); chk("R9 flags cleared", d, 0);
        rd_now(2'd3, d); chk("R9 result kept", d, saved);

        // R10 zero count
        wr(2'd0, mk(0, 1, 1'b0, 1'b1));
        @(posedge clk); #1.5 rd_now(2'd2, d); chk("R10 ready next cycle, not busy", d, 1);
        rd_now(2'd3, d); chk("R10 result zero", d, 0);
        wr(2'd0, mk(0, 1, 1'b0, 1'b0));

        // R6 synchroniser latency with hand-driven source 0
        launch(1, 0, 1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk); man0 = 1'b1;
        @(posedge clk); #1.5 rd_now(2'd2, d); chk("R6 not counted at edge k", d, 4);
        @(posedge clk); #1.5 rd_now(2'd2, d); chk("R6 not counted at edge k+1", d, 4);
        @(posedge clk); #1.5 rd_now(2'd2, d); chk("R6 counted at edge k+2", d, 1);
        man0 = 1'b0;

        // R8 start edge while busy is ignored
        wr(2'd0, mk(5, 3, 1'b0, 1'b0));
        t0 = cyc_now;
        wr(2'd0, mk(5, 3, 1'b0, 1'b1));
        repeat (50) @(posedge clk);
        wr(2'd0, mk(5, 3, 1'b0, 1'b0));
        wr(2'd0, mk(5, 3, 1'b0, 1'b1));
        rd(2'd2, d); chk("R8 still busy after retrigger", d, 4);
        wait_idle();
        chk_in("R8 run not restarted (cycles to finish)", cyc_now - t0, 150, 208);
        rd(2'd3, saved);

        // R5 timeout
        wr(2'd1, 32'd10);
        launch(2, 3, 1'b0);
        repeat (20) @(posedge clk);
        rd(2'd2, d); chk("R5 timeout flag only", d, 2);
        rd_now(2'd3, d); chk("R5 result kept on timeout", d, saved);
        wr(2'd1, 32'd1000);
        launch(2, 1, 1'b0);
        wait_idle();
        rd(2'd2, d); chk("R5 next run completes", d, 1);
        rd_now(2'd3, d); chk_in("R5 next run result", d, 11, 23);

        // R11 saturation
        wr(2'd1, RMAX);
        launch(40, 3, 1'b0);
        wait_idle();
        rd(2'd3, d); chk("R11 saturated result", d, RMAX);
        wr(2'd1, 32'd1000);

        // R1 / R7 cycling on every source
        src0_auto = 1'b1;
        for (int s = 0; s < 4; s++) begin
            launch(3, s, 1'b1);
            wait_done(2);
            rd(2'd3, d); chk("R1 period result for selected source", d, 6 * hp[s]);
            rd_now(2'd2, d); chk("R7 cycling keeps busy and ready", d, 5);
            wait_done(1);
            rd(2'd3, d); chk("R7 result refreshed each period", d, 6 * hp[s]);
            wr(2'd0, mk(3, s, 1'b0, 1'b0));
            wait_done(1);
            repeat (2) @(posedge clk);
            rd(2'd2, d); chk("R7 run ends after cycling cleared", d, 1);
        end

        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule